// File: doc/BRIEF.md
# Multi-Register Block Transfer Sequencer

This block moves a run of consecutive general registers to or from memory, one word per beat. A transfer covers every register from a chosen top index down to register 0. The first register goes to or from the start address, and each later register uses the next word up. The start address is the contents of a base register, read through the register-file read port when the command is taken. When a prefix address is active, that address is used as the start address instead.

A command is a one-cycle `start` pulse carrying the direction, top index, base index, autoincrement flag and prefix state. The sequencer has three named states. `ST_IDLE` takes the command and latches it (transition IDLE→XFER on `start`). `ST_XFER` issues one memory request per register and holds the address and index until the memory acknowledges (transition XFER→WRBACK on the acknowledge of the register-0 beat). `ST_WRBACK` writes the base register when autoincrement is selected and pulses `done` (transition WRBACK→IDLE unconditionally). In autoincrement mode the value written back depends on whether a prefix was used. On a store with both a prefix and autoincrement, the slot belonging to the base register carries the start address in place of the register's contents.

Top module: `blkxfer_seq`

## Requirements
- R1: Registers are transferred from the top index down to register 0, one per acknowledged beat. The memory address begins at the start address and rises by 4 bytes after each acknowledged beat, so register i uses address start + 4*(top - i).
- R2: The start address equals `pfx_addr` when `pfx_valid` is 1 at `start`. Otherwise it equals the contents of register `base_reg`, read at `start`.
- R3: With `autoinc`=1 and `pfx_valid`=0, the base register ends holding start + 4*(top + 1), the address just past the last word.
- R4: With `autoinc`=1 and `pfx_valid`=1, the base register ends holding the start address.
- R5: On a store (`store_mode`=1) with `autoinc`=1 and `pfx_valid`=1, if `base_reg` is at most `top_reg`, the memory word for the base register receives the start address. Every other slot receives the register's contents.
- R6: On a load (`store_mode`=0), every register in the range is written from memory in descending order, and the base writeback comes after all of them. A store never writes the register file during its beats.
- R7: With `autoinc`=0, no register is written other than the loaded range, and a store leaves the register file unchanged.
- R8: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `rf_raddr` and `mem_req` hold their values into the next cycle.
- R9: `done` is high for exactly one cycle per command, in the cycle after the last acknowledged beat, and `busy` falls after it.
- R10: A top index of 0 transfers exactly one word.
- R11: After reset, `busy`, `done`, `mem_req` and `rf_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command pulse, taken while idle |
| store_mode | input | 1 | 1: registers to memory, 0: memory to registers |
| top_reg | input | 4 | Highest register index in the run |
| base_reg | input | 4 | Index of the base register |
| autoinc | input | 1 | 1: write the base register back at the end |
| pfx_valid | input | 1 | 1: a prefix address replaces the base register as start |
| pfx_addr | input | 32 | Prefix start address |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1: beat is a write |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| mem_ack | input | 1 | Beat accepted this cycle |

## Verification
The embedded assertions check the per-cycle rules on every cycle:
- the address and index hold during a stall and step by one word and one register per accepted beat;
- `done` lasts a single cycle;
- the register file is not written during store beats;
- the base register is not written back in indirect mode.

The bench's scenarios cover the effects that only appear in final state: the substituted store word, the two writeback values, a load that overwrites its own base register before writeback, and the one-word transfer. It sweeps every top index against several base indices, both directions, both modes, both prefix states and three memory latencies, and compares the register file and memory against values it computes.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_WRBACK = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/blkxfer_cursor.sv
module blkxfer_cursor #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int STRIDE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [IDX_W-1:0]  load_idx,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] first_addr,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              last
);

    localparam logic [ADDR_W-1:0] ADDR_INC = ADDR_W'(STRIDE);
    localparam logic [IDX_W-1:0]  IDX_DEC  = IDX_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr   <= '0;
            first_addr <= '0;
            cur_idx    <= '0;
        end else if (load) begin
            cur_addr   <= load_addr;
            first_addr <= load_addr;
            cur_idx    <= load_idx;
        end else if (step) begin
            cur_addr <= cur_addr + ADDR_INC;
            if (cur_idx != '0) begin
                cur_idx <= cur_idx - IDX_DEC;
            end
        end
    end

    assign last = (cur_idx == '0);

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
    import blkxfer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic mem_ack,
    input  logic last,
    output logic load,
    output logic step,
    output logic mem_req,
    output logic wb_phase,
    output logic busy,
    output logic done
);

    xfer_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_XFER;
            ST_XFER:   if (mem_ack && last) state_d = ST_WRBACK;
            ST_WRBACK: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load     = 1'b0;
        step     = 1'b0;
        mem_req  = 1'b0;
        wb_phase = 1'b0;
        unique case (state_q)
            ST_IDLE:   load = start;
            ST_XFER: begin
                mem_req = 1'b1;
                step    = mem_ack;
            end
            ST_WRBACK: wb_phase = 1'b1;
            default: ;
        endcase
        busy = (state_q != ST_IDLE);
        done = wb_phase;
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> mem_req); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && last) |=> done); // R9

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic                        store_mode,
    input  logic [$clog2(NUM_REGS)-1:0] top_reg,
    input  logic [$clog2(NUM_REGS)-1:0] base_reg,
    input  logic                        autoinc,
    input  logic                        pfx_valid,
    input  logic [DATA_W-1:0]           pfx_addr,
    output logic                        busy,
    output logic                        done,
    output logic [$clog2(NUM_REGS)-1:0] rf_raddr,
    input  logic [DATA_W-1:0]           rf_rdata,
    output logic                        rf_we,
    output logic [$clog2(NUM_REGS)-1:0] rf_waddr,
    output logic [DATA_W-1:0]           rf_wdata,
    output logic                        mem_req,
    output logic                        mem_we,
    output logic [DATA_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_wdata,
    input  logic [DATA_W-1:0]           mem_rdata,
    input  logic                        mem_ack
);

    localparam int IDX_W  = $clog2(NUM_REGS);
    localparam int STRIDE = DATA_W / 8;
    localparam logic [DATA_W-1:0] ADDR_INC = DATA_W'(STRIDE);

    logic              load, step, wb_phase, last;
    logic [DATA_W-1:0] cur_addr, first_addr, start_addr;
    logic [IDX_W-1:0]  cur_idx;

    logic              store_q, autoinc_q, pfx_q;
    logic [IDX_W-1:0]  base_q;
    logic              subst_slot, beat_write, base_write;

    blkxfer_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .mem_ack  (mem_ack),
        .last     (last),
        .load     (load),
        .step     (step),
        .mem_req  (mem_req),
        .wb_phase (wb_phase),
        .busy     (busy),
        .done     (done)
    );

    assign start_addr = pfx_valid ? pfx_addr : rf_rdata;

    blkxfer_cursor #(
        .ADDR_W (DATA_W),
        .IDX_W  (IDX_W),
        .STRIDE (STRIDE)
    ) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .load_addr  (start_addr),
        .load_idx   (top_reg),
        .cur_addr   (cur_addr),
        .first_addr (first_addr),
        .cur_idx    (cur_idx),
        .last       (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q   <= 1'b0;
            autoinc_q <= 1'b0;
            pfx_q     <= 1'b0;
            base_q    <= '0;
        end else if (load) begin
            store_q   <= store_mode;
            autoinc_q <= autoinc;
            pfx_q     <= pfx_valid;
            base_q    <= base_reg;
        end
    end

    // While idle the read port fetches the base register for the start address.
    assign rf_raddr   = busy ? cur_idx : base_reg;

    assign subst_slot = store_q && pfx_q && autoinc_q && (cur_idx == base_q);
    assign mem_we     = mem_req && store_q;
    assign mem_addr   = cur_addr;
    assign mem_wdata  = subst_slot ? first_addr : rf_rdata;

    assign beat_write = mem_req && mem_ack && !store_q;
    assign base_write = wb_phase && autoinc_q;
    assign rf_we      = beat_write || base_write;
    assign rf_waddr   = base_write ? base_q : cur_idx;
    assign rf_wdata   = base_write ? (pfx_q ? first_addr : cur_addr) : mem_rdata;

    AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !last) |=> (mem_addr == $past(mem_addr) + ADDR_INC)); // R1
    AST_IDX_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !last) |=> (rf_raddr == $past(rf_raddr) - IDX_W'(1))); // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(rf_raddr))); // R8
    AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !rf_we); // R6
    AST_INDIRECT_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !autoinc_q) |-> !rf_we); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !rf_we)); // R11

endmodule

// File: tb/blkxfer_seq_tb.sv
`timescale 1ns/1ps
module blkxfer_seq_tb;

    localparam int NR = 16;
    localparam int MW = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, store_mode, autoinc, pfx_valid;
    logic [3:0]  top_reg, base_reg;
    logic [31:0] pfx_addr;
    logic        busy, done;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] rf  [NR];
    logic [31:0] mem [MW];
    int          lat, wcnt, beats, dones;
    int          nchk = 0, nerr = 0;

    always #2.5 clk = ~clk;

    blkxfer_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .store_mode(store_mode),
        .top_reg(top_reg), .base_reg(base_reg), .autoinc(autoinc),
        .pfx_valid(pfx_valid), .pfx_addr(pfx_addr), .busy(busy), .done(done),
        .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
        .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign rf_rdata  = rf[rf_raddr];
    assign mem_rdata = mem[mem_addr[7:2]];
    assign mem_ack   = mem_req && (wcnt >= lat);

    always @(posedge clk) begin
        if (mem_req && !mem_ack) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_req && mem_ack && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (mem_req && mem_ack) beats <= beats + 1;
        if (done) dones <= dones + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit st, input bit ai, input bit pf,
                          input int top, input int base, input int seed);
        logic [31:0] erf  [NR];
        logic [31:0] emem [MW];
        logic [31:0] baddr, paddr, sa;
        string       rtag, mtag, btag;
        int          guard;
        baddr = 32'((seed % 7) * 8);
        paddr = 32'h40 + 32'((seed % 5) * 4);
        for (int i = 0; i < NR; i++) rf[i] = 32'hA500_0000 + 32'(seed * 256 + i);
        rf[base] = baddr;
        for (int k = 0; k < MW; k++) mem[k] = 32'h5A00_0000 ^ 32'(k << 8) ^ 32'(seed);
        sa = pf ? paddr : baddr;
        for (int i = 0; i < NR; i++) erf[i] = rf[i];
        for (int k = 0; k < MW; k++) emem[k] = mem[k];
        for (int i = top; i >= 0; i--) begin
            int w = int'(sa >> 2) + (top - i);
            if (st) emem[w] = (pf && ai && i == base) ? sa : rf[i];
            else    erf[i]  = mem[w];
        end
        if (ai) erf[base] = pf ? sa : sa + 32'(4 * (top + 1));
        if (st) mtag = (pf && ai && base <= top) ? "R5 store slot" : "R1 store order/R2";
        else    mtag = "R1 memory untouched on load";
        if (!ai)      rtag = "R7 no writeback";
        else if (pf)  rtag = "R4 writeback start";
        else          rtag = "R3 writeback end";
        if (!st && ai && base <= top) rtag = {rtag, "/R6 load then writeback"};
        else if (!st) rtag = {rtag, "/R2 load start"};
        btag = (top == 0) ? "R10 one word" : ((lat > 0) ? "R8 beat count" : "R1 beat count");

        lat   = seed % 3;
        beats = 0;
        dones = 0;
        store_mode = st; autoinc = ai; pfx_valid = pf;
        top_reg = 4'(top); base_reg = 4'(base); pfx_addr = paddr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        chk(done, "R9 done reached", 32'(done), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk(!busy, "R9 busy falls", 32'(busy), 32'd0);
        chk(dones == 1, "R9 single done", 32'(dones), 32'd1);
        chk(beats == top + 1, btag, 32'(beats), 32'(top + 1));
        for (int i = 0; i < NR; i++) chk(rf[i] == erf[i], rtag, rf[i], erf[i]);
        for (int k = 0; k < MW; k++) chk(mem[k] == emem[k], mtag, mem[k], emem[k]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int seed;
        int bases [3];
        bases[0] = 0; bases[1] = 5; bases[2] = 15;
        rst_n = 1'b0; start = 1'b0; store_mode = 1'b0; autoinc = 1'b0;
        pfx_valid = 1'b0; top_reg = '0; base_reg = '0; pfx_addr = '0;
        lat = 0; wcnt = 0; beats = 0; dones = 0;
        for (int i = 0; i < NR; i++) rf[i] = '0;
        for (int k = 0; k < MW; k++) mem[k] = '0;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R11 reset busy/done", {30'd0, busy, done}, 32'd0);
        chk(!mem_req && !rf_we, "R11 reset req/we", {30'd0, mem_req, rf_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        seed = 1;
        for (int st = 0; st < 2; st++)
            for (int ai = 0; ai < 2; ai++)
                for (int pf = 0; pf < 2; pf++)
                    for (int top = 0; top < NR; top++)
                        for (int b = 0; b < 3; b++) begin
                            run_op(st[0], ai[0], pf[0], top, bases[b], seed);
                            seed++;
                        end
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule